// File: doc/BRIEF.md
# Cue-Driven Associative Memory Array

The block holds a small array of stored words. Each word is a row of one-bit cells, and each cell sits on a column that receives one bit of a cue vector. When a recall strobe is applied, an enable signal enters every row at both ends. One copy travels rightward and one travels leftward, cell by cell. A cell passes the enable onward in two cases: its column's cue bit is clear, or its cue bit is set and its own stored bit is also set. A cell whose cue bit is set but whose stored bit is clear kills the enable.

A word matches when both directional chains reach the opposite end of the row. Matching is therefore a subset test: every cued attribute must be present in the word, and attributes that were not cued are free. The array returns the bitwise OR of all matching words, so a single match gives back the complete stored word, including the bits the cue did not name. The block also reports one match flag per word, an any-match flag and a multi-match flag.

Words are loaded through a synchronous write port. All recall results are registered and appear one clock after the strobe.

Top module: `cue_assoc_mem`

## Requirements
- R1: While rst_ni is low, every stored word is cleared and match_o, data_o, any_match_o and multi_match_o are 0. After reset, a recall with cue 16'hFFFF matches no word.
- R2: When wr_en_i is 1 at a rising clock edge, the word at wr_addr_i takes the value wr_data_i. When wr_en_i is 0, no stored word changes.
- R3: A clock edge at which recall_i is 0 leaves match_o, data_o, any_match_o and multi_match_o at 0 for the following cycle, whatever cue_i holds.
- R4: A cue bit of 0 passes the enable regardless of the stored bit. A recall with cue_i = 0 therefore matches every word, including all-zero words.
- R5: Word i matches (match_o[i] = 1) exactly when every set cue bit is also set in word i, that is when (cue_i & ~word_i) == 0. Both the rightward chain and the leftward chain must complete.
- R6: data_o is the bitwise OR of all matching words, uncued bits included. It is 0 when no word matches.
- R7: any_match_o is 1 when at least one word matches. multi_match_o is 1 when two or more words match.
- R8: The results of a recall appear on the outputs in the cycle after the edge at which recall_i was 1. A write at that same edge is not seen by that recall, but it is seen by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 3 | Word address for a write |
| wr_data_i | input | 16 | Data for a write |
| cue_i | input | 16 | Cue vector, one bit per column |
| recall_i | input | 1 | Recall strobe; drives both chain entries |
| match_o | output | 8 | Registered per-word match flags |
| data_o | output | 16 | Registered OR of all matching words |
| any_match_o | output | 1 | Registered: at least one match |
| multi_match_o | output | 1 | Registered: two or more matches |

## Verification
The bench sweeps every single-bit cue, the empty cue, the all-ones cue, each stored word used as its own cue, and several hundred sparse pseudo-random cues. For each recall it derives the expected match vector and merged data by arithmetic over a mirror of the words it wrote.

These cues expose specific faults:
- A cell that compared for equality instead of the subset rule would lose matches on the empty and sparse cues.
- A cell that ignored its stored bit would match on the all-ones cue after reset.
- A merge that took a single word would drop bits when several words match.

Further cases cover the dormant behaviour with a live cue and the strobe low, and a write that is disabled. A write landing on the same edge as a recall exposes a read-after-write path that returns the new value one cycle early.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned WORDS_DEF = 8;
  localparam int unsigned WIDTH_DEF = 16;

  // enable survives when the column is uncued or the cued bit is held
  function automatic logic cell_pass(input logic en, input logic cue, input logic stored);
    return en & (~cue | stored);
  endfunction
endpackage

// File: rtl/cam_cell.sv
module cam_cell (
  input  logic q_i,
  input  logic cue_i,
  input  logic rin_i,
  input  logic lin_i,
  output logic rout_o,
  output logic lout_o
);
  assign rout_o = cam_pkg::cell_pass(rin_i, cue_i, q_i);
  assign lout_o = cam_pkg::cell_pass(lin_i, cue_i, q_i);
endmodule

// File: rtl/cam_word_row.sv
module cam_word_row #(
  parameter int unsigned WIDTH = cam_pkg::WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] cue_i,
  input  logic             strobe_i,
  output logic [WIDTH-1:0] word_o,
  output logic             match_o
);
  logic [WIDTH-1:0] store_q;
  logic [WIDTH:0]   r_chain;
  logic [WIDTH:0]   l_chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= '0;
    else if (we_i) store_q <= wdata_i;
  end

  assign r_chain[0]     = strobe_i;
  assign l_chain[WIDTH] = strobe_i;

  for (genvar c = 0; c < WIDTH; c++) begin : g_cell
    cam_cell cell_i (
      .q_i   (store_q[c]),
      .cue_i (cue_i[c]),
      .rin_i (r_chain[c]),
      .lin_i (l_chain[c+1]),
      .rout_o(r_chain[c+1]),
      .lout_o(l_chain[c])
    );
  end

  assign word_o  = store_q;
  assign match_o = r_chain[WIDTH] & l_chain[0];
endmodule

// File: rtl/cam_merge.sv
module cam_merge #(
  parameter int unsigned WORDS = cam_pkg::WORDS_DEF,
  parameter int unsigned WIDTH = cam_pkg::WIDTH_DEF
) (
  input  logic [WORDS-1:0]            match_i,
  input  logic [WORDS-1:0][WIDTH-1:0] words_i,
  output logic [WIDTH-1:0]            data_o,
  output logic                        any_o,
  output logic                        multi_o
);
  always_comb begin
    logic seen;
    seen    = 1'b0;
    multi_o = 1'b0;
    data_o  = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (match_i[w]) begin
        data_o  = data_o | words_i[w];
        multi_o = multi_o | seen;
        seen    = 1'b1;
      end
    end
    any_o = seen;
  end
endmodule

// File: rtl/cue_assoc_mem.sv
module cue_assoc_mem #(
  parameter int unsigned NUM_WORDS = cam_pkg::WORDS_DEF,
  parameter int unsigned WORD_W    = cam_pkg::WIDTH_DEF,
  localparam int unsigned ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [WORD_W-1:0] cue_i,
  input  logic              recall_i,
  output logic [NUM_WORDS-1:0] match_o,
  output logic [WORD_W-1:0]    data_o,
  output logic                 any_match_o,
  output logic                 multi_match_o
);
  logic [NUM_WORDS-1:0]             row_match;
  logic [NUM_WORDS-1:0][WORD_W-1:0] row_word;
  logic [WORD_W-1:0]                merged;
  logic                             any_d, multi_d;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_row
    cam_word_row #(.WIDTH(WORD_W)) row_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_addr_i == ADDR_W'(w))),
      .wdata_i (wr_data_i),
      .cue_i   (cue_i),
      .strobe_i(recall_i),
      .word_o  (row_word[w]),
      .match_o (row_match[w])
    );
  end

  cam_merge #(.WORDS(NUM_WORDS), .WIDTH(WORD_W)) merge_i (
    .match_i(row_match),
    .words_i(row_word),
    .data_o (merged),
    .any_o  (any_d),
    .multi_o(multi_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o       <= '0;
      data_o        <= '0;
      any_match_o   <= 1'b0;
      multi_match_o <= 1'b0;
    end else begin
      match_o       <= row_match;
      data_o        <= merged;
      any_match_o   <= any_d;
      multi_match_o <= multi_d;
    end
  end
endmodule

// File: rtl/cue_assoc_mem_chk.sv
module cue_assoc_mem_chk #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WORD_W-1:0]    cue_i,
  input logic                 recall_i,
  input logic [NUM_WORDS-1:0] match_o,
  input logic [WORD_W-1:0]    data_o,
  input logic                 any_match_o,
  input logic                 multi_match_o
);
  // R1
  always @(posedge clk_i)
    if (!rst_ni)
      reset_clear_chk: assert (match_o == '0 && data_o == '0 && !any_match_o && !multi_match_o);

  // R3
  dormant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recall_i |=> (match_o == '0 && data_o == '0 && !any_match_o && !multi_match_o));

  // R4
  empty_cue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recall_i && cue_i == '0) |=> (&match_o));

  // R6
  data_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != '0) |-> any_match_o);

  // R7
  any_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_match_o == (match_o != '0));

  // R7
  multi_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_match_o == ($countones(match_o) > 1));
endmodule

bind cue_assoc_mem cue_assoc_mem_chk #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cue_i        (cue_i),
  .recall_i     (recall_i),
  .match_o      (match_o),
  .data_o       (data_o),
  .any_match_o  (any_match_o),
  .multi_match_o(multi_match_o)
);

// File: tb/cue_assoc_mem_tb_top.sv
module cue_assoc_mem_tb_top;
  localparam int NW = 8;
  localparam int WW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_addr_i = '0;
  logic [WW-1:0] wr_data_i = '0;
  logic [WW-1:0] cue_i = '0;
  logic          recall_i = 1'b0;
  logic [NW-1:0] match_o;
  logic [WW-1:0] data_o;
  logic          any_match_o, multi_match_o;

  logic [WW-1:0] mirror [NW];
  int tests = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  cue_assoc_mem dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .cue_i, .recall_i,
    .match_o, .data_o, .any_match_o, .multi_match_o
  );

  task automatic check_out(input string tag, input logic [NW-1:0] em, input logic [WW-1:0] ed,
                           input logic ea, input logic emu);
    tests++;
    if (match_o !== em || data_o !== ed || any_match_o !== ea || multi_match_o !== emu) begin
      fails++;
      $display("FAIL %s cue=%h match=%b exp=%b data=%h exp=%h any=%b exp=%b multi=%b exp=%b",
               tag, cue_i, match_o, em, data_o, ed, any_match_o, ea, multi_match_o, emu);
    end
  endtask

  task automatic expect_for(input logic [WW-1:0] cue, output logic [NW-1:0] em,
                            output logic [WW-1:0] ed, output logic ea, output logic emu);
    int n = 0;
    em = '0; ed = '0;
    for (int w = 0; w < NW; w++)
      if ((cue & ~mirror[w]) == '0) begin
        em[w] = 1'b1; ed = ed | mirror[w]; n++;
      end
    ea = (n > 0); emu = (n > 1);
  endtask

  task automatic recall(input logic [WW-1:0] cue, input string tag);
    logic [NW-1:0] em; logic [WW-1:0] ed; logic ea, emu;
    @(negedge clk_i);
    cue_i = cue; recall_i = 1'b1;
    expect_for(cue, em, ed, ea, emu);
    @(negedge clk_i);
    recall_i = 1'b0;
    check_out(tag, em, ed, ea, emu);
  endtask

  task automatic write_word(input int a, input logic [WW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    mirror[a] = d;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [NW-1:0] em; logic [WW-1:0] ed; logic ea, emu;
    for (int w = 0; w < NW; w++) mirror[w] = '0;
    #2 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check_out("R1 reset", '0, '0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    recall('1, "R1 storage cleared");
    recall('0, "R4 empty cue after reset");

    for (int w = 0; w < NW; w++)
      write_word(w, WW'((w + 1) * 16'h0913) ^ (16'h1111 << (w % 4)));
    write_word(6, mirror[1] | 16'h8001);
    write_word(7, 16'h0000);

    // R3 live cue with strobe low
    @(negedge clk_i);
    cue_i = 16'h0000; recall_i = 1'b0;
    @(negedge clk_i);
    check_out("R3 dormant", '0, '0, 1'b0, 1'b0);

    recall('0, "R4 empty cue all words");
    recall('1, "R5 full cue");
    for (int b = 0; b < WW; b++) recall(WW'(1) << b, "R5 single bit cue");
    for (int w = 0; w < NW; w++) recall(mirror[w], "R6 own word cue");

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      recall(lfsr & (lfsr >> 5) & (lfsr << 3), "R7 sparse cue");
    end

    // R2 disabled write leaves word 3 unchanged
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = 3'd3; wr_data_i = ~mirror[3];
    @(negedge clk_i);
    recall(mirror[3], "R2 disabled write");

    // R8 write at the recall edge is not seen by that recall
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 16'hF00F;
    cue_i = 16'hF00F; recall_i = 1'b1;
    expect_for(16'hF00F, em, ed, ea, emu);
    @(negedge clk_i);
    wr_en_i = 1'b0; recall_i = 1'b0;
    mirror[5] = 16'hF00F;
    check_out("R8 same edge write", em, ed, ea, emu);
    recall(16'hF00F, "R8 write seen next");
    recall(16'h0000, "R2 written word in merge");

    // R3 strobe low after a matching recall
    @(negedge clk_i);
    cue_i = 16'hF00F;
    @(negedge clk_i);
    check_out("R3 dormant after recall", '0, '0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule